// File: doc/BRIEF.md
# Six-Operand End-Around-Carry Modular Summation Core

This block adds six unsigned operands of 4n bits each, modulo 2^(4n)-1. It is the summation stage of a residue-to-binary converter. In that converter the modulus 2^(4n)-1 is the product of the odd moduli (2^n-1)(2^n+1)(2^(2n)+1), and the fourth modulus is 2^(2n).

The six operands reach the block already prepared. A tree of four 3:2 carry-save stages reduces them to two vectors. Each stage rotates its top carry bit back into bit 0, which is exact because 2^(4n) is congruent to 1 under this modulus. A final two-pass end-around-carry adder resolves the two vectors and folds the redundant all-ones code onto zero.

The 2n-bit residue modulo 2^(2n) is then placed below the 4n-bit modular sum, which gives the 6n-bit binary result. A parameter adds one register stage after the carry-save tree. With the default n = 4, the sum is 16 bits and the result is 24 bits.

Top module: `eac_sum6`

## Requirements
- R1: `sum_z` equals the arithmetic sum of `op_a` through `op_f`, reduced modulo 2^(4n)-1, using the value in force when that sum was sampled.
- R2: `sum_z` never shows the all-ones code. A sum that is a multiple of the modulus shows as zero, so `sum_z` stays within 0 to 2^(4n)-2.
- R3: `word_x` is the concatenation of `sum_z` in bits [6n-1:2n] and the low residue in bits [2n-1:0].
- R4: With `PIPE_EN` = 1 (the default), `sum_z` and `word_x` change only at a rising `clk` edge. They reflect the operands and residue sampled at that edge. With `PIPE_EN` = 0, the path is purely combinational.
- R5: While `rst_n` is low and `PIPE_EN` = 1, `sum_z` and `word_x` read zero.
- R6: Swapping operands between input ports does not change `sum_z`.
- R7: An operand at all ones (2^(4n)-1) counts as zero: `sum_z` is the same as if that operand were zero.
- R8: Each carry-save stage keeps the sum of its three inputs modulo 2^(4n)-1 in the sum of its two outputs.
- R9: A total of exactly the modulus plus one gives `sum_z` = 1. A total of the modulus minus one gives 2^(4n)-2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional register stage |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| op_a | input | 4n | Prepared operand 0 |
| op_b | input | 4n | Prepared operand 1 |
| op_c | input | 4n | Prepared operand 2 |
| op_d | input | 4n | Prepared operand 3 |
| op_e | input | 4n | Prepared operand 4 |
| op_f | input | 4n | Prepared operand 5 |
| low_res | input | 2n | Residue modulo 2^(2n) |
| sum_z | output | 4n | Modular sum, 0 to 2^(4n)-2 |
| word_x | output | 6n | Reconstructed binary result |

## Verification
The assertions assume that the operands and the low residue hold known values at every clock edge after reset. They also assume that `rst_n` is released away from a clock edge. The bench satisfies both. It drives every input to a defined value from time zero and changes inputs only on the falling edge. It drops and raises reset on falling edges only, so the registered stage always samples settled data.

// File: rtl/eac_sum_pkg.sv
package eac_sum_pkg;

  // Residue of v modulo 2^w - 1 (w below 64); used by checks only.
  function automatic longint unsigned ring_mod(input longint unsigned v,
                                               input int unsigned w);
    longint unsigned m;
    m = (64'd1 << w) - 64'd1;
    return v % m;
  endfunction

endpackage

// File: rtl/eac_csa.sv
module eac_csa #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] in_x,
  input  logic [W-1:0] in_y,
  input  logic [W-1:0] in_z,
  output logic [W-1:0] out_s,
  output logic [W-1:0] out_c
);

  logic [W-1:0] maj;

  always_comb begin
    out_s = in_x ^ in_y ^ in_z;
    maj   = (in_x & in_y) | (in_x & in_z) | (in_y & in_z);
    // weight 2^W folds onto weight 1 under modulus 2^W - 1
    out_c = {maj[W-2:0], maj[W-1]};
  end

endmodule

// File: rtl/eac_cpa.sv
module eac_cpa #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] vec_s,
  input  logic [W-1:0] vec_c,
  output logic [W-1:0] total
);

  logic [W:0]   pass1;
  logic [W-1:0] pass2;

  always_comb begin
    pass1 = {1'b0, vec_s} + {1'b0, vec_c};
    // second pass adds the carry-out; no overflow possible here
    pass2 = pass1[W-1:0] + {{(W-1){1'b0}}, pass1[W]};
    // all ones is the redundant zero
    total = (&pass2) ? '0 : pass2;
  end

endmodule

// File: rtl/eac_sum6.sv
module eac_sum6
  import eac_sum_pkg::*;
#(
  parameter int unsigned N       = 4,
  parameter bit          PIPE_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4*N-1:0]    op_a,
  input  logic [4*N-1:0]    op_b,
  input  logic [4*N-1:0]    op_c,
  input  logic [4*N-1:0]    op_d,
  input  logic [4*N-1:0]    op_e,
  input  logic [4*N-1:0]    op_f,
  input  logic [2*N-1:0]    low_res,
  output logic [4*N-1:0]    sum_z,
  output logic [6*N-1:0]    word_x
);

  localparam int unsigned W      = 4 * N;
  localparam int unsigned RW     = 2 * N;
  localparam int unsigned STAGES = 4;

  logic [W-1:0] st_x [STAGES];
  logic [W-1:0] st_y [STAGES];
  logic [W-1:0] st_z [STAGES];
  logic [W-1:0] st_s [STAGES];
  logic [W-1:0] st_c [STAGES];

  // tree wiring: two leaf stages, then two merge stages
  always_comb begin
    st_x[0] = op_a;    st_y[0] = op_b;    st_z[0] = op_c;
    st_x[1] = op_d;    st_y[1] = op_e;    st_z[1] = op_f;
    st_x[2] = st_s[0]; st_y[2] = st_c[0]; st_z[2] = st_s[1];
    st_x[3] = st_s[2]; st_y[3] = st_c[2]; st_z[3] = st_c[1];
  end

  for (genvar g = 0; g < STAGES; g++) begin : g_csa
    eac_csa #(.W(W)) u_csa (
      .in_x (st_x[g]),
      .in_y (st_y[g]),
      .in_z (st_z[g]),
      .out_s(st_s[g]),
      .out_c(st_c[g])
    );
  end

  logic [W-1:0]  hold_s, hold_c;
  logic [RW-1:0] hold_low;

  if (PIPE_EN) begin : g_pipe
    logic [W-1:0]  nxt_s, nxt_c;
    logic [RW-1:0] nxt_low;

    always_comb begin
      nxt_s   = st_s[STAGES-1];
      nxt_c   = st_c[STAGES-1];
      nxt_low = low_res;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hold_s   <= '0;
        hold_c   <= '0;
        hold_low <= '0;
      end else begin
        hold_s   <= nxt_s;
        hold_c   <= nxt_c;
        hold_low <= nxt_low;
      end
    end
  end else begin : g_comb
    always_comb begin
      hold_s   = st_s[STAGES-1];
      hold_c   = st_c[STAGES-1];
      hold_low = low_res;
    end
  end

  eac_cpa #(.W(W)) u_cpa (
    .vec_s(hold_s),
    .vec_c(hold_c),
    .total(sum_z)
  );

  always_comb word_x = {sum_z, hold_low};

  // ---------------- assertions ----------------
  logic [63:0] ref_now;
  always_comb ref_now = ring_mod(64'(op_a) + 64'(op_b) + 64'(op_c)
                               + 64'(op_d) + 64'(op_e) + 64'(op_f), W);

  for (genvar g = 0; g < STAGES; g++) begin : g_chk
    // R8: each compressor conserves the residue
    a_r8_stage_conserve: assert property (@(posedge clk) disable iff (!rst_n)
      ring_mod(64'(st_x[g]) + 64'(st_y[g]) + 64'(st_z[g]), W)
        == ring_mod(64'(st_s[g]) + 64'(st_c[g]), W));
  end

  // R2: redundant zero never leaves the block
  a_r2_no_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    sum_z != {W{1'b1}});

  if (PIPE_EN) begin : g_pipe_chk
    // R1 / R4: result follows operands sampled one edge earlier
    a_r1_mod_sum: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (64'(sum_z) == $past(ref_now)));
    // R3: low field carries the sampled residue
    a_r3_low_field: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (word_x[RW-1:0] == $past(low_res)));
    // R5: outputs cleared while reset is held
    a_r5_reset_zero: assert property (@(posedge clk)
      !rst_n |-> (sum_z == '0 && word_x == '0));
  end else begin : g_comb_chk
    a_r1_mod_sum: assert property (@(posedge clk) disable iff (!rst_n)
      64'(sum_z) == ref_now);
    a_r3_low_field: assert property (@(posedge clk) disable iff (!rst_n)
      word_x[RW-1:0] == low_res);
  end

endmodule

// File: tb/tb_eac_sum6.sv
module tb_eac_sum6;

  localparam int unsigned N      = 4;
  localparam int unsigned W      = 4 * N;
  localparam int unsigned RW     = 2 * N;
  localparam int unsigned XW     = 6 * N;
  localparam time         CLK_T  = 10ns;
  localparam longint unsigned MOD = (64'd1 << W) - 64'd1;

  logic clk, rst_n;
  logic [W-1:0]  op [6];
  logic [RW-1:0] low_res;
  logic [W-1:0]  sum_z;
  logic [XW-1:0] word_x;

  int n_cmp, n_bad;
  logic [31:0] rng;

  eac_sum6 #(.N(N), .PIPE_EN(1'b1)) dut (
    .clk(clk), .rst_n(rst_n),
    .op_a(op[0]), .op_b(op[1]), .op_c(op[2]),
    .op_d(op[3]), .op_e(op[4]), .op_f(op[5]),
    .low_res(low_res), .sum_z(sum_z), .word_x(word_x)
  );

  initial clk = 1'b0;
  always #(CLK_T/2) clk = ~clk;

  function automatic longint unsigned ref_sum(input longint unsigned a0, a1, a2,
                                              a3, a4, a5);
    return (a0 + a1 + a2 + a3 + a4 + a5) % MOD;
  endfunction

  task automatic chk(input string req, input longint unsigned act,
                     input longint unsigned exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] step_rng(input logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  // drive at falling edge, check just after the next rising edge
  task automatic apply(input longint unsigned v0, v1, v2, v3, v4, v5,
                       input logic [RW-1:0] lr, input string req);
    longint unsigned e;
    @(negedge clk);
    op[0] = W'(v0); op[1] = W'(v1); op[2] = W'(v2);
    op[3] = W'(v3); op[4] = W'(v4); op[5] = W'(v5);
    low_res = lr;
    @(posedge clk); #1;
    e = ref_sum(64'(op[0]), 64'(op[1]), 64'(op[2]),
                64'(op[3]), 64'(op[4]), 64'(op[5]));
    chk(req, 64'(sum_z), e);
    chk("R3", 64'(word_x), {e[W-1:0], lr});
  endtask

  task automatic t_reset();
    @(negedge clk);
    op[0] = '1; op[1] = 16'h1234; low_res = 8'hA5;
    rst_n = 1'b0;
    #1;
    chk("R5", 64'(sum_z), 0);
    chk("R5", 64'(word_x), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_zero();
    apply(0, 0, 0, 0, 0, 0, 8'h00, "R1");
  endtask

  task automatic t_all_ones();
    apply(MOD, MOD, MOD, MOD, MOD, MOD, 8'hFF, "R2");
    chk("R2", 64'(sum_z), 0);
    apply(MOD - 1, 1, 0, 0, 0, 0, 8'h01, "R2");
    chk("R2", 64'(sum_z), 0);
  endtask

  task automatic t_boundary();
    apply(64'h8000, 64'h8000, 0, 0, 0, 0, 8'h3C, "R9");
    chk("R9", 64'(sum_z), 1);
    apply(MOD - 1, 0, 0, 0, 0, 0, 8'h7E, "R9");
    chk("R9", 64'(sum_z), MOD - 1);
    apply(MOD - 1, MOD - 1, MOD - 1, MOD - 1, MOD - 1, MOD - 1, 8'h81, "R1");
    chk("R1", 64'(sum_z), MOD - 6);
  endtask

  task automatic t_ones_as_zero();
    longint unsigned base;
    apply(16'h0F0F, 16'h1111, 0, 16'h00AA, 16'h7000, 16'h0003, 8'h10, "R7");
    base = 64'(sum_z);
    apply(16'h0F0F, 16'h1111, MOD, 16'h00AA, 16'h7000, 16'h0003, 8'h10, "R7");
    chk("R7", 64'(sum_z), base);
  endtask

  task automatic t_order();
    longint unsigned first;
    apply(16'hDEAD, 16'hBEEF, 16'hCAFE, 16'hF00D, 16'h1357, 16'h2468, 8'h55, "R6");
    first = 64'(sum_z);
    apply(16'h2468, 16'hF00D, 16'h1357, 16'hBEEF, 16'hDEAD, 16'hCAFE, 8'h55, "R6");
    chk("R6", 64'(sum_z), first);
  endtask

  task automatic t_latency();
    longint unsigned old_z;
    apply(16'h0101, 16'h0202, 0, 0, 0, 0, 8'h22, "R4");
    old_z = 64'(sum_z);
    @(negedge clk);
    op[0] = 16'h4000; op[1] = 16'h0004;
    #1;
    chk("R4", 64'(sum_z), old_z);
    @(posedge clk); #1;
    chk("R4", 64'(sum_z), 64'h4004);
  endtask

  task automatic t_random();
    // exercises R1, R8 and R3 across mixed carry patterns
    for (int i = 0; i < 300; i++) begin
      longint unsigned v[6];
      for (int k = 0; k < 6; k++) begin
        rng = step_rng(rng);
        v[k] = 64'(rng[W-1:0]);
      end
      rng = step_rng(rng);
      apply(v[0], v[1], v[2], v[3], v[4], v[5], rng[RW-1:0], "R8");
    end
  endtask

  initial begin
    n_cmp = 0; n_bad = 0;
    rng = 32'h1BADF00D;
    rst_n = 1'b0;
    for (int k = 0; k < 6; k++) op[k] = '0;
    low_res = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_zero();
    t_all_ones();
    t_boundary();
    t_ones_as_zero();
    t_order();
    t_latency();
    t_random();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_T * 20000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule